// File: doc/BRIEF.md
# Nested Vectored Interrupt Priority Controller

This block sits between twenty level-sensitive interrupt request lines and a processor core. Each source has a 3-bit priority level from 0 to 7, where 0 is the most urgent. A per-source routing bit sends the source to one of two request classes: the normal request output (`irq_o`) or the fast request output (`fiq_o`). For each class the controller keeps a vector word. Software reads this word to find the slot that holds the handler pointer for the winning source.

Each class has its own nesting enable and its own 8-bit in-service stack, with one bit per priority level. With nesting enabled, a read of the class vector marks the winner's level as in service. Every level at or below the lowest in-service level is then held off the output until software retires it. Each write to the in-service register retires one level: the most urgent one that is set. With nesting disabled, priorities are ignored and the lowest-numbered pending source wins. In that fixed mode a pending fast request holds the normal request output low.

Software reaches all state through a word-wide register port. Reads return data one cycle after `reg_rd`.

Top module: `nvic_prio_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_o` and `fiq_o` are 0, and the control word, routing word, vector base, all priorities and both in-service stacks are 0.
- R2: While control bit 0 is 0, the normal class ignores priorities and never sets in-service bits. Its vector names the lowest-numbered pending source routed to it. While control bit 0 is 0 and any source routed to the fast class is pending, `irq_o` is 0.
- R3: While a class's nesting bit is 1 (bit 0 for normal, bit 1 for fast), its winner is the eligible pending source with the smallest priority level. Ties go to the lowest source number.
- R4: A read of a class vector (address 3 for normal, 4 for fast) while that class's nesting bit is 1 and some source is eligible sets the in-service bit whose index equals the winner's level.
- R5: While in-service bit k of a class is set, and k is the lowest set bit, sources of that class with level k or higher are not eligible. A source with a level below k still raises the output.
- R6: Any write to an in-service register (address 5 for normal, 6 for fast) clears only the lowest-numbered set bit, whatever data is written. An empty stack stays empty.
- R7: The vector word is {9'b0, base[15:0], source[4:0], 2'b00}. Source 8 appears as 5'b01000 in bits 6:2.
- R8: When no source of a class is eligible, its output is 0, its vector source field is 0, and a vector read sets no in-service bit.
- R9: The fast class behaves like the normal class, using control bit 1, its own vector at address 4 and its own stack at address 6. Its actions never alter the normal stack.
- R10: Routing bit i (address 1) set to 1 sends source i to the fast class, and 0 sends it to the normal class. Outputs are registered and follow a change of sources or state on the next clock edge.
- R11: Register map. Address 0 is control, bits 1:0. Address 2 is the vector base, bits 15:0. Address 8+k holds the priorities of sources 8k to 8k+7, with source 8k+j at bits 4j+2:4j. Every writable register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 20 | Level interrupt requests, bit i is source i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Normal-class request |
| fiq_o | output | 1 | Fast-class request |

## Verification
The bench covers five corner cases. The first is an equal-level source raised while its level is in service. A design that compares with "less than or equal" against the mask would raise `irq_o` for it. The second is a more urgent source arriving during service, which must raise the output again and push a second bit; a design that masks everything while the stack is non-empty would stay silent. The third is the retire order from 0x05: the stack must pass through 0x04 to 0x00, regardless of the data written. A design that cleared the top bit, or used the written data as a mask, shows a different sequence. The fourth covers fixed mode with both enables clear, where priorities must be ignored and a pending fast source must hold `irq_o` low. The fifth is ties on level and vector reads with nothing pending, which must return a zero source field and leave the stack untouched.

// File: rtl/nvic_pkg.sv
package nvic_pkg;
  // Word addresses of the register port
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_ROUTE = 4'd1;
  localparam logic [3:0] A_BASE  = 4'd2;
  localparam logic [3:0] A_IVEC  = 4'd3;
  localparam logic [3:0] A_FVEC  = 4'd4;
  localparam logic [3:0] A_ISTK  = 4'd5;
  localparam logic [3:0] A_FSTK  = 4'd6;
  localparam logic [3:0] A_PRIO  = 4'd8;

  // Request classes, used as generate indices
  localparam int CL_IRQ = 0;
  localparam int CL_FIQ = 1;
  localparam int NCLASS = 2;

  // Priority fields are packed on a nibble stride in the priority words
  localparam int PRIO_STRIDE = 4;
  localparam int PRIO_PER_WORD = 8;
endpackage

// File: rtl/nvic_arb.sv
module nvic_arb #(
  parameter int NSRC = 20,
  parameter int PW   = 3,
  parameter int SW   = 5
) (
  input  logic [NSRC-1:0]    pend,
  input  logic [NSRC*PW-1:0] prio_flat,
  input  logic               nest_en,
  input  logic [PW:0]        thr,
  output logic               hit,
  output logic [SW-1:0]      src,
  output logic [PW-1:0]      lvl
);
  logic [PW:0]   best;
  logic [PW-1:0] p;

  // Scan from the top index down so an equal level at a lower index wins.
  always_comb begin
    hit  = 1'b0;
    src  = '0;
    lvl  = '0;
    best = {1'b1, {PW{1'b0}}};
    p    = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      p = nest_en ? prio_flat[i*PW +: PW] : '0;
      if (pend[i] && (!nest_en || ({1'b0, p} < thr)) && ({1'b0, p} <= best)) begin
        hit  = 1'b1;
        src  = SW'(i);
        lvl  = p;
        best = {1'b0, p};
      end
    end
  end
endmodule

// File: rtl/nvic_stk.sv
module nvic_stk #(
  parameter int NLVL = 8,
  parameter int PW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [PW-1:0]   push_lvl,
  input  logic            pop,
  output logic [NLVL-1:0] stk,
  output logic [PW:0]     thr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stk <= '0;
    end else if (pop) begin
      stk <= stk & (stk - 1'b1);
    end else if (push) begin
      stk <= stk | (NLVL'(1) << push_lvl);
    end
  end

  // Lowest set level is the masking threshold; NLVL means nothing masked.
  always_comb begin
    thr = (PW+1)'(NLVL);
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (stk[i]) thr = (PW+1)'(i);
    end
  end
endmodule

// File: rtl/nvic_prio_ctrl.sv
module nvic_prio_ctrl
  import nvic_pkg::*;
#(
  parameter int NSRC = 20,
  parameter int PW   = 3,
  parameter int BW   = 16,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int NLVL = 1 << PW;
  localparam int SW   = $clog2(NSRC);

  logic [NCLASS-1:0] ctrl_q;
  logic [NSRC-1:0]   route_q;
  logic [BW-1:0]     base_q;
  logic [PW-1:0]     prio_q [NSRC];
  logic [NSRC*PW-1:0] prio_flat;

  logic [NSRC-1:0]   pend   [NCLASS];
  logic              hit    [NCLASS];
  logic [SW-1:0]     win    [NCLASS];
  logic [PW-1:0]     wlvl   [NCLASS];
  logic [NLVL-1:0]   stk_q  [NCLASS];
  logic [PW:0]       thr    [NCLASS];
  logic [DW-1:0]     vec    [NCLASS];
  logic [DW-1:0]     rd_mux;

  for (genvar i = 0; i < NSRC; i++) begin : g_flat
    assign prio_flat[i*PW +: PW] = prio_q[i];
  end

  for (genvar c = 0; c < NCLASS; c++) begin : g_cls
    assign pend[c] = src_i & ((c == CL_FIQ) ? route_q : ~route_q);

    nvic_arb #(.NSRC(NSRC), .PW(PW), .SW(SW)) u_arb (
      .pend      (pend[c]),
      .prio_flat (prio_flat),
      .nest_en   (ctrl_q[c]),
      .thr       (thr[c]),
      .hit       (hit[c]),
      .src       (win[c]),
      .lvl       (wlvl[c])
    );

    nvic_stk #(.NLVL(NLVL), .PW(PW)) u_stk (
      .clk      (clk),
      .rst      (rst),
      .push     (reg_rd && reg_addr == AW'(A_IVEC + c) && ctrl_q[c] && hit[c]),
      .push_lvl (wlvl[c]),
      .pop      (reg_wr && reg_addr == AW'(A_ISTK + c)),
      .stk      (stk_q[c]),
      .thr      (thr[c])
    );

    assign vec[c] = (DW'(base_q) << (SW + 2)) | (DW'(win[c]) << 2);
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      route_q <= '0;
      base_q  <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else if (reg_wr) begin
      if (reg_addr == AW'(A_CTRL))  ctrl_q  <= reg_wdata[NCLASS-1:0];
      if (reg_addr == AW'(A_ROUTE)) route_q <= reg_wdata[NSRC-1:0];
      if (reg_addr == AW'(A_BASE))  base_q  <= reg_wdata[BW-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (reg_addr == AW'(A_PRIO + i / PRIO_PER_WORD))
          prio_q[i] <= reg_wdata[(i % PRIO_PER_WORD)*PRIO_STRIDE +: PW];
      end
    end
  end

  // Read multiplexer
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      AW'(A_CTRL):  rd_mux = DW'(ctrl_q);
      AW'(A_ROUTE): rd_mux = DW'(route_q);
      AW'(A_BASE):  rd_mux = DW'(base_q);
      AW'(A_IVEC):  rd_mux = vec[CL_IRQ];
      AW'(A_FVEC):  rd_mux = vec[CL_FIQ];
      AW'(A_ISTK):  rd_mux = DW'(stk_q[CL_IRQ]);
      AW'(A_FSTK):  rd_mux = DW'(stk_q[CL_FIQ]);
      default: begin
        for (int i = 0; i < NSRC; i++) begin
          if (reg_addr == AW'(A_PRIO + i / PRIO_PER_WORD))
            rd_mux[(i % PRIO_PER_WORD)*PRIO_STRIDE +: PW] = prio_q[i];
        end
      end
    endcase
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq_o <= hit[CL_IRQ] && !(!ctrl_q[CL_IRQ] && hit[CL_FIQ]);
      fiq_o <= hit[CL_FIQ];
    end
  end
endmodule

// File: rtl/nvic_prio_chk.sv
module nvic_prio_chk #(
  parameter int NLVL = 8,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_rd,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_rdata,
  input logic [1:0]      ctrl_q,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [NLVL-1:0] irq_stk,
  input logic [NLVL-1:0] fiq_stk
);
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!irq_o && !fiq_o)); // R1

  AST_FIXED_FIQ_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q[0] == 1'b0) && fiq_o) |-> !irq_o); // R2

  AST_FIXED_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[0] |=> ($countones(irq_stk) <= $countones($past(irq_stk)))); // R2

  AST_PUSH_ONE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(irq_stk) <= $countones($past(irq_stk)) + 1)); // R4

  AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == AW'(5) && irq_stk != '0)
      |=> ($countones(irq_stk) == $countones($past(irq_stk)) - 1)); // R6

  AST_VEC_PAD: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd && (reg_addr == AW'(3) || reg_addr == AW'(4)))
      |-> (reg_rdata[1:0] == 2'b00 && reg_rdata[31:23] == 9'd0)); // R7

  AST_FIQ_KEEPS_IRQ_STK: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == AW'(4)) |=> (irq_stk == $past(irq_stk))); // R9
endmodule

bind nvic_prio_ctrl nvic_prio_chk #(.NLVL(1 << PW), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .ctrl_q    (ctrl_q),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .irq_stk   (stk_q[0]),
  .fiq_stk   (stk_q[1])
);

// File: tb/nvic_prio_ctrl_tb.sv
module nvic_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] src_i = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nvic_prio_ctrl u_dut (
    .clk(clk), .rst(rst), .src_i(src_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 fiq_o", 32'(fiq_o), 0);
    rd(4'd0, d); chk("R1 ctrl", d, 0);
    rd(4'd5, d); chk("R1 irq stack", d, 0);
    rd(4'd6, d); chk("R1 fiq stack", d, 0);
  endtask

  task automatic t_fixed();
    logic [31:0] d;
    wr(4'd0, 0);
    wr(4'd8, 32'h0000_7000);            // src3 level 7, src5 level 0
    src_i = 20'h00028;                  // sources 3 and 5
    settle();
    chk("R2 irq_o fixed", 32'(irq_o), 1);
    rd(4'd3, d); chk("R2 lowest number wins", d, 32'(3 << 2));
    rd(4'd5, d); chk("R2 no push in fixed", d, 0);
    wr(4'd1, 32'h0_0400);               // R10 route source 10 to fast
    src_i = src_i | 20'h00400;
    settle();
    chk("R2 fiq_o", 32'(fiq_o), 1);
    chk("R2 irq held by fiq", 32'(irq_o), 0);
    rd(4'd4, d); chk("R10 fast vector", d, 32'(10 << 2));
    src_i = 20'h00028;
    settle();
    chk("R2 irq back", 32'(irq_o), 1);
    chk("R10 fiq low", 32'(fiq_o), 0);
    src_i = '0;
    wr(4'd1, 0);
  endtask

  task automatic t_format();
    logic [31:0] d;
    wr(4'd2, 32'h0000_ABCD);
    rd(4'd2, d); chk("R11 base readback", d, 32'h0000_ABCD);
    src_i = 20'h00100;                  // source 8
    settle();
    rd(4'd3, d); chk("R7 vector word", d, (32'hABCD << 7) | 32'h20);
    src_i = '0;
    settle();
    chk("R8 irq_o idle", 32'(irq_o), 0);
    rd(4'd3, d); chk("R8 idle vector", d, 32'hABCD << 7);
    wr(4'd2, 0);
  endtask

  task automatic t_nest();
    logic [31:0] d;
    wr(4'd0, 1);
    wr(4'd8, 32'h2005_0000);            // src4 level 5, src7 level 2
    wr(4'd9, 32'h0000_0020);            // src9 level 2, src12 level 0
    rd(4'd9, d); chk("R11 prio readback", d, 32'h0000_0020);
    rd(4'd3, d); chk("R8 nothing eligible vector", d, 0);
    rd(4'd5, d); chk("R8 no push when idle", d, 0);
    src_i = 20'h00210;                  // sources 4 and 9
    settle();
    chk("R3 irq_o", 32'(irq_o), 1);
    rd(4'd3, d); chk("R3 smallest level wins", d, 32'(9 << 2));
    rd(4'd5, d); chk("R4 push level 2", d, 32'h04);
    settle();
    chk("R5 masked at and below", 32'(irq_o), 0);
    src_i = src_i | 20'h00080;          // source 7, equal level
    settle();
    chk("R5 equal level blocked", 32'(irq_o), 0);
    src_i = src_i | 20'h01000;          // source 12, level 0
    settle();
    chk("R5 preempt", 32'(irq_o), 1);
    rd(4'd3, d); chk("R3 preempting vector", d, 32'(12 << 2));
    rd(4'd5, d); chk("R4 nested push", d, 32'h05);
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, d); chk("R6 first clear", d, 32'h04);
    settle();
    chk("R5 unmasked after clear", 32'(irq_o), 1);
    wr(4'd5, 0);
    rd(4'd5, d); chk("R6 second clear data ignored", d, 0);
    wr(4'd5, 32'h5A);
    rd(4'd5, d); chk("R6 empty stays empty", d, 0);
    src_i = 20'h00290;                  // sources 4, 7, 9
    settle();
    rd(4'd3, d); chk("R3 tie lowest number", d, 32'(7 << 2));
    wr(4'd5, 0);
    src_i = '0;
  endtask

  task automatic t_fast_nest();
    logic [31:0] d;
    wr(4'd0, 2);
    wr(4'd1, 32'h1_8000);               // sources 15,16 fast
    wr(4'd9, 32'h4000_0020);            // src15 level 4
    wr(4'd10, 32'h1);                   // src16 level 1
    src_i = 20'h18000;
    settle();
    chk("R9 fiq_o", 32'(fiq_o), 1);
    rd(4'd4, d); chk("R9 fast vector", d, 32'(16 << 2));
    rd(4'd6, d); chk("R9 fast stack", d, 32'h02);
    rd(4'd5, d); chk("R9 normal stack untouched", d, 0);
    settle();
    chk("R9 fast masked", 32'(fiq_o), 0);
    wr(4'd6, 0);
    rd(4'd6, d); chk("R9 fast clear", d, 0);
    settle();
    chk("R9 fast again", 32'(fiq_o), 1);
    src_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_format();
    t_nest();
    t_fast_nest();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule